// File: doc/BRIEF.md
# Interleaved Video/CPU DRAM Slot Sequencer

This block produces the row strobe, column strobe and address-multiplexer select for one dynamic memory that is shared between video refresh and the processor. A free-running four-bit slot counter, clocked by the 28.63636 MHz master clock, walks through sixteen slots. Slots 0 to 7 form the video half. Slots 8 to 15 form the CPU half. Each half lasts eight master clocks, about 279 ns. Video strobes fire in every video half. CPU-half strobes fire only when a processor request has been caught in time for that half.

Requests pass through two stages. A pending flag collects any request high at a clock edge. On the edge that enters slot 8, the pending flag (or a request present at that same edge) is promoted to the access flag. The access flag then stays set through the CPU half and ends when the row strobe returns high in the following video half. A request that arrives after that edge waits for the next CPU half.

The block also gives three auxiliary pulses: a frame sync at slot 0, a video-data latch pulse where the multiplexer select rises in the CPU half, and a CPU read-data latch pulse during an access. The outputs are decoded directly from registered state.

Top module: `dram_slot_seq`

## Requirements
- R1: The slot counter counts 0 to 15 and wraps to 0. `st15` is high exactly in slot 0, which is one clock in sixteen.
- R2: In the video half (slots 0-7, phase = slot bits [2:0]), `ras_n` is low for phases 1-5 and `cas_n` is low for phases 3-5, whatever the request input does.
- R3: `mux` is high for phases 2-5 in both halves and low otherwise.
- R4: In the CPU half (slots 8-15), `ras_n` and `cas_n` follow the same phase pattern as R2 only while `cpu_cycle` is high. Otherwise both stay high for the whole half.
- R5: `cpu_cycle` rises only on entry to slot 8. It rises if a request was seen at any clock edge since the previous slot-8 entry, including the entry edge itself.
- R6: A request sampled after the slot-8 entry edge is held pending and is served in the next CPU half. It is never dropped.
- R7: Once set, `cpu_cycle` stays high through slots 8-15 and 0-5 and falls on entry to slot 6.
- R8: `dymux` is a one-clock pulse in slot 10 of every frame, with or without an access.
- R9: `cpult` is a one-clock pulse in slot 13, only when `cpu_cycle` is high.
- R10: Synchronous active-high `rst` forces slot 0 and clears the pending request and `cpu_cycle`. While `rst` is held, the outputs read `ras_n`=1, `cas_n`=1, `mux`=0, `st15`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (28.63636 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor memory request, sampled on each rising edge |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| mux | output | 1 | Address multiplexer select, high for column address |
| st15 | output | 1 | Frame sync pulse in slot 0 |
| dymux | output | 1 | Video data latch pulse in slot 10 |
| cpult | output | 1 | CPU read-data latch pulse in slot 13 during an access |
| cpu_cycle | output | 1 | CPU access in progress |

## Verification
A wrong slot count moves `st15`, `dymux` and the strobe edges by the same amount. This shows at the ports within one frame of sixteen clocks. A lost or duplicated request changes `cpu_cycle` and the CPU-half `ras_n`/`cas_n` pattern at the next slot-8 entry, which is at most sixteen clocks away. An access flag that ends at the wrong slot gives an extra or missing `cpult`, or a `cpu_cycle` fall outside slot 6, within the same frame.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

    localparam int SLOT_W    = 4;
    localparam int PH_W      = SLOT_W - 1;
    localparam int HALF_LEN  = 1 << PH_W;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [PH_W-1:0]   phase_t;

    // phase positions inside one half
    localparam phase_t PH_RAS_ON = phase_t'(1);
    localparam phase_t PH_MUX_ON = phase_t'(2);
    localparam phase_t PH_CAS_ON = phase_t'(3);
    localparam phase_t PH_OFF    = phase_t'(6);
    localparam phase_t PH_RDLAT  = phase_t'(5);

    // absolute slots derived from the phase positions
    localparam slot_t SLOT_SYNC       = slot_t'(0);
    localparam slot_t SLOT_CPU_FIRST  = slot_t'(HALF_LEN);
    localparam slot_t SLOT_LAST_VIDEO = slot_t'(HALF_LEN - 1);
    localparam slot_t SLOT_ACC_END    = slot_t'(int'(PH_OFF) - 1);
    localparam slot_t SLOT_VID_LATCH  = slot_t'(HALF_LEN + int'(PH_MUX_ON));
    localparam slot_t SLOT_CPU_LATCH  = slot_t'(HALF_LEN + int'(PH_RDLAT));

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic mux;
        logic st15;
        logic dymux;
        logic cpult;
    } strobe_t;

    typedef struct packed {
        logic pend;
        logic act;
    } req_state_t;

    function automatic phase_t phase_of(slot_t s);
        return s[PH_W-1:0];
    endfunction

    function automatic logic is_cpu_half(slot_t s);
        return s[SLOT_W-1];
    endfunction

    function automatic logic in_span(phase_t ph, phase_t lo, phase_t hi_excl);
        return (ph >= lo) && (ph < hi_excl);
    endfunction

endpackage

// File: rtl/slot_counter.sv
module slot_counter
    import dram_slot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_t slot
);

    always_ff @(posedge clk) begin
        if (rst) slot <= SLOT_SYNC;
        else     slot <= slot + slot_t'(1);
    end

    // R1
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == '1) |=> (slot == '0));

endmodule

// File: rtl/req_gate.sv
module req_gate
    import dram_slot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_req,
    input  slot_t slot,
    output logic  cpu_act
);

    req_state_t st_q, st_d;
    logic       start_edge, end_edge, pend_any;

    assign start_edge = (slot == SLOT_LAST_VIDEO);
    assign end_edge   = (slot == SLOT_ACC_END);
    assign pend_any   = st_q.pend | cpu_req;

    always_comb begin
        st_d = st_q;
        if (start_edge) begin
            st_d.act  = pend_any;
            st_d.pend = 1'b0;
        end else begin
            st_d.pend = pend_any;
            if (end_edge) st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cpu_act = st_q.act;

    // R5
    act_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.act) |-> (slot == SLOT_CPU_FIRST));

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && slot != SLOT_LAST_VIDEO) |=> st_q.pend);

    // R7
    act_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.act && slot == SLOT_ACC_END) |=> !st_q.act);

    // R7
    act_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.act && is_cpu_half(slot)) |=> st_q.act);

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import dram_slot_pkg::*;
(
    input  slot_t   slot,
    input  logic    cpu_act,
    output strobe_t strb
);

    phase_t ph;
    logic   slot_en;

    always_comb begin
        ph      = phase_of(slot);
        slot_en = !is_cpu_half(slot) || cpu_act;
        strb.ras_n = !(slot_en && in_span(ph, PH_RAS_ON, PH_OFF));
        strb.cas_n = !(slot_en && in_span(ph, PH_CAS_ON, PH_OFF));
        strb.mux   = in_span(ph, PH_MUX_ON, PH_OFF);
        strb.st15  = (slot == SLOT_SYNC);
        strb.dymux = (slot == SLOT_VID_LATCH);
        strb.cpult = cpu_act && (slot == SLOT_CPU_LATCH);
    end

endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
    import dram_slot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    output logic ras_n,
    output logic cas_n,
    output logic mux,
    output logic st15,
    output logic dymux,
    output logic cpult,
    output logic cpu_cycle
);

    slot_t   slot;
    logic    cpu_act;
    strobe_t strb;

    slot_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    req_gate u_req (
        .clk     (clk),
        .rst     (rst),
        .cpu_req (cpu_req),
        .slot    (slot),
        .cpu_act (cpu_act)
    );

    strobe_decode u_dec (
        .slot    (slot),
        .cpu_act (cpu_act),
        .strb    (strb)
    );

    assign ras_n     = strb.ras_n;
    assign cas_n     = strb.cas_n;
    assign mux       = strb.mux;
    assign st15      = strb.st15;
    assign dymux     = strb.dymux;
    assign cpult     = strb.cpult;
    assign cpu_cycle = cpu_act;

    // R4
    cpu_half_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cpu_half(slot) && !cpu_act) |-> (ras_n && cas_n));

    // R2
    video_cas_chk: assert property (@(posedge clk) disable iff (rst)
        (!cas_n) |-> (!ras_n && mux));

    // R8
    dymux_mux_chk: assert property (@(posedge clk) disable iff (rst)
        dymux |-> (mux && is_cpu_half(slot)));

    // R9
    cpult_act_chk: assert property (@(posedge clk) disable iff (rst)
        cpult |-> (cpu_act && !cas_n));

    // R1
    sync_once_chk: assert property (@(posedge clk) disable iff (rst)
        st15 |=> !st15);

endmodule

// File: tb/dram_slot_seq_tb_top.sv
module dram_slot_seq_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0;
    logic ras_n, cas_n, mux, st15, dymux, cpult, cpu_cycle;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state, derived from the requirements
    int m_slot = 0;
    bit m_pend = 0;
    bit m_act  = 0;

    always #5 clk = ~clk;

    dram_slot_seq dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req),
        .ras_n(ras_n), .cas_n(cas_n), .mux(mux), .st15(st15),
        .dymux(dymux), .cpult(cpult), .cpu_cycle(cpu_cycle)
    );

    // request patterns, bit i drives clock i of a 32-clock run
    localparam logic [31:0] REQ_PAT [6] = '{
        32'h0000_0000,
        32'h0000_0080,
        32'h0000_0200,
        32'hFFFF_FFFF,
        32'h8001_0101,
        32'h00F0_0F00
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s slot=%0d got=%b exp=%b", tag, m_slot, got, exp);
        end
    endtask

    task automatic compare_all();
        int ph = m_slot % 8;
        bit cpu_h = (m_slot >= 8);
        bit en = !cpu_h || m_act;
        chk("R1 st15", st15, m_slot == 0);
        chk(cpu_h ? "R4 ras_n" : "R2 ras_n", ras_n, !(en && ph >= 1 && ph <= 5));
        chk(cpu_h ? "R4 cas_n" : "R2 cas_n", cas_n, !(en && ph >= 3 && ph <= 5));
        chk("R3 mux", mux, ph >= 2 && ph <= 5);
        chk("R8 dymux", dymux, m_slot == 10);
        chk("R9 cpult", cpult, m_act && m_slot == 13);
        chk("R7 cpu_cycle", cpu_cycle, m_act);
    endtask

    // compare now, drive inputs, advance the model across one rising edge
    task automatic step(input logic req, input logic rv);
        bit pn;
        compare_all();
        cpu_req = req;
        rst = rv;
        pn = m_pend | req;
        if (rv) begin
            m_slot = 0; m_pend = 0; m_act = 0;
        end else begin
            if (m_slot == 7) begin
                m_act = pn; m_pend = 0;
            end else begin
                m_pend = pn;
                if (m_slot == 5) m_act = 0;
            end
            m_slot = (m_slot + 1) % 16;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_to(input int s);
        while (m_slot != s) step(1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 ras_n", ras_n, 1'b1);
        chk("R10 cas_n", cas_n, 1'b1);
        chk("R10 mux", mux, 1'b0);
        chk("R10 st15", st15, 1'b1);
        chk("R10 cpu_cycle", cpu_cycle, 1'b0);
        rst = 1'b0;
        m_slot = 0; m_pend = 0; m_act = 0;

        // table walk
        for (int p = 0; p < 6; p++)
            for (int i = 0; i < 32; i++)
                step(REQ_PAT[p][i], 1'b0);
        go_to(0);

        // R5: request only on the edge that enters slot 8
        go_to(7);
        step(1'b1, 1'b0);
        chk("R5 start at slot8", cpu_cycle, 1'b1);
        go_to(6);
        chk("R7 drop at slot6", cpu_cycle, 1'b0);

        // R6: request in mid CPU half waits for next half
        go_to(9);
        step(1'b1, 1'b0);
        go_to(12);
        chk("R6 no late start", cpu_cycle, 1'b0);
        chk("R6 cpu ras quiet", ras_n, 1'b1);
        go_to(8);
        chk("R6 served next half", cpu_cycle, 1'b1);
        go_to(13);
        chk("R9 cpult served", cpult, 1'b1);
        go_to(0);

        // R10: reset mid-run drops a pending request
        go_to(10);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        chk("R10 st15 after rst", st15, 1'b1);
        chk("R10 idle after rst", cpu_cycle, 1'b0);
        step(1'b0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
        chk("R10 pending cleared", cpu_cycle, 1'b0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule